// File: doc/BRIEF.md
# Receive MAC Dispatch Filter

This block sits after frame validation on the receive side of a multi-channel Ethernet controller. It decides which of up to eight virtual channels should store an incoming frame. Frame bytes arrive one per valid cycle. The first six bytes carry the destination MAC address. The block compares that address against a 48-bit address held for each channel. It keeps only the channels whose visibility bit is set, and it also handles the all-ones broadcast address. When the sixth byte arrives the block settles the target set of channels. It then asserts a per-channel write enable on a one-cycle-delayed copy of the byte stream, from that sixth byte to the end of the frame.

Each channel owns two receive buffers that are filled in turn. The block keeps a buffer select bit for each channel. It refuses a frame when the buffer that channel would fill next is marked full. A refused frame gives a one-cycle drop pulse instead of write enables. Four statistics counters record the following:

- frames that reach a decision;
- broadcast frames seen;
- drops caused by the destination address;
- drops caused by a full channel.

Software can overwrite any of the counters through a small load port.

Top module: `rx_mac_steer`

## Requirements
- R1: After reset, `wr_en`, `drop`, `wr_buf` and all four counters read zero.
- R2: The destination is the first six bytes of a frame, most significant byte first. Channel c's address is `ch_mac[48*c+47 : 48*c]`, and the first byte is compared with bits 47:40. The decision is taken on the sixth valid byte. One cycle after each valid byte, from the sixth through the last, `out_byte` and `out_last` echo that byte, and `wr_en` shows the chosen channels. Idle gaps in `in_valid` give no writes.
- R3: A non-broadcast frame goes to a visible channel whose address equals the destination. If several match, it goes only to the lowest-numbered one.
- R4: A channel whose `ch_vis` bit is 0 never matches. A non-broadcast frame with no visible match is dropped, and `cnt_dst_fail` increments.
- R5: A frame with destination FF:FF:FF:FF:FF:FF increments `cnt_bc`. With `bcast_en` set, it goes to every visible channel whose next buffer is free. With `bcast_en` clear, or with no visible channel, it is dropped as a destination failure.
- R6: A frame whose matched channel has its next buffer full is dropped, and `cnt_ch_full` increments. A permitted broadcast that finds no visible channel with room is also dropped and counted in `cnt_ch_full`.
- R7: Each channel's buffer select `wr_buf[c]` starts at 0 and inverts in the cycle after the last byte of a frame is written to that channel. Room for channel c means `buf_full[2*c + wr_buf[c]]` is 0.
- R8: Once taken, the decision holds to the end of the frame, whatever `ch_vis`, `bcast_en` or `buf_full` do afterwards.
- R9: A frame whose last byte arrives before its sixth byte produces no write, no drop and no counter change.
- R10: `cnt_rx` increments by one for every frame that reaches a decision, whether delivered or dropped.
- R11: When `cnt_we` is high at a clock edge, the counter chosen by `cnt_sel` loads `cnt_wdata`, overriding any increment. The codes are 0 = `cnt_rx`, 1 = `cnt_bc`, 2 = `cnt_dst_fail` and 3 = `cnt_ch_full`. The other counters keep their values.
- R12: A dropped frame gives exactly one `drop` cycle, one cycle after the sixth byte, and no `wr_en` for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_byte | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the final byte of its frame |
| ch_mac | input | 48*NCH | Per-channel destination address |
| ch_vis | input | NCH | Channel enable bits |
| bcast_en | input | 1 | Accept broadcast frames |
| buf_full | input | 2*NCH | Full flag per channel buffer, bit 2c+b |
| cnt_we | input | 1 | Load a counter |
| cnt_sel | input | 2 | Counter to load |
| cnt_wdata | input | CW | Load value |
| wr_en | output | NCH | Per-channel write enable for `out_byte` |
| wr_buf | output | NCH | Per-channel buffer select |
| out_byte | output | 8 | Delayed frame byte |
| out_last | output | 1 | Delayed last-byte marker |
| drop | output | 1 | Frame refused |
| cnt_rx | output | CW | Frames decided |
| cnt_bc | output | CW | Broadcast frames seen |
| cnt_dst_fail | output | CW | Drops on address |
| cnt_ch_full | output | CW | Drops on full channel |

## Verification
The following directed frames are used:

- A unicast frame to one channel with no gaps, and the same with gaps between bytes. These show that the write window starts at the sixth byte and ignores idle cycles.
- An unknown address, an address belonging to a disabled channel, and two channels sharing one address. These separate a miss from a masked hit and check lowest-index priority.
- Broadcast frames with the enable off, with it on and one buffer full, and with every buffer full. These distinguish a destination drop, partial delivery and a full-channel drop.
- Repeated frames to one channel while its two buffers fill one after the other, a runt, and a configuration change in the middle of a frame. These expose buffer alternation, the decision point and the holding of the decision.

// File: rtl/rx_mac_steer.sv
module rx_mac_steer #(
  parameter int NCH = 8,
  parameter int CW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  input  logic [NCH*48-1:0] ch_mac,
  input  logic [NCH-1:0]    ch_vis,
  input  logic              bcast_en,
  input  logic [2*NCH-1:0]  buf_full,
  input  logic              cnt_we,
  input  logic [1:0]        cnt_sel,
  input  logic [CW-1:0]     cnt_wdata,
  output logic [NCH-1:0]    wr_en,
  output logic [NCH-1:0]    wr_buf,
  output logic [7:0]        out_byte,
  output logic              out_last,
  output logic              drop,
  output logic [CW-1:0]     cnt_rx,
  output logic [CW-1:0]     cnt_bc,
  output logic [CW-1:0]     cnt_dst_fail,
  output logic [CW-1:0]     cnt_ch_full
);

  localparam logic [2:0] POS_DEC  = 3'd5;
  localparam logic [2:0] POS_BODY = 3'd6;

  logic [2:0]     pos;
  logic [39:0]    hdr;
  logic [NCH-1:0] sel, ptr, hit, room, pick, mask;
  logic           is_bc, fail_dst, fail_full;
  logic [47:0]    dst;
  logic           at_dec;
  logic [CW-1:0]  cnt [4];
  logic [3:0]     bump;

  assign dst    = {hdr, in_byte};
  assign at_dec = in_valid && (pos == POS_DEC);
  assign is_bc  = &dst;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c]  = ch_vis[c] && (ch_mac[c*48 +: 48] == dst);
    assign room[c] = ptr[c] ? ~buf_full[2*c+1] : ~buf_full[2*c];

    always_ff @(posedge clk) begin
      if (!rst_n)                   ptr[c] <= 1'b0;
      else if (wr_en[c] && out_last) ptr[c] <= ~ptr[c];
    end
  end

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
    if (is_bc) begin
      fail_dst = !bcast_en || (ch_vis == '0);
      mask     = fail_dst ? '0 : (ch_vis & room);
    end else begin
      fail_dst = (hit == '0);
      mask     = pick & room;
    end
    fail_full = !fail_dst && (mask == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      hdr <= '0;
      sel <= '0;
    end else if (in_valid) begin
      if (in_last)              pos <= '0;
      else if (pos != POS_BODY) pos <= pos + 3'd1;
      if (pos < POS_DEC)        hdr <= {hdr[31:0], in_byte};
      if (in_last)              sel <= '0;
      else if (at_dec)          sel <= mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en    <= '0;
      out_byte <= '0;
      out_last <= 1'b0;
      drop     <= 1'b0;
    end else begin
      if (at_dec)                             wr_en <= mask;
      else if (in_valid && pos == POS_BODY)   wr_en <= sel;
      else                                    wr_en <= '0;
      if (in_valid) out_byte <= in_byte;
      out_last <= in_valid && in_last && (pos >= POS_DEC);
      drop     <= at_dec && (mask == '0);
    end
  end

  assign bump = {at_dec & fail_full, at_dec & fail_dst, at_dec & is_bc, at_dec};

  for (genvar k = 0; k < 4; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                           cnt[k] <= '0;
      else if (cnt_we && cnt_sel == 2'(k))  cnt[k] <= cnt_wdata;
      else if (bump[k])                     cnt[k] <= cnt[k] + CW'(1);
    end
  end

  assign wr_buf       = ptr;
  assign cnt_rx       = cnt[0];
  assign cnt_bc       = cnt[1];
  assign cnt_dst_fail = cnt[2];
  assign cnt_ch_full  = cnt[3];

endmodule

// File: rtl/rx_mac_steer_chk.sv
module rx_mac_steer_chk #(
  parameter int NCH = 8,
  parameter int CW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] wr_en,
  input logic [NCH-1:0] wr_buf,
  input logic           out_last,
  input logic           drop,
  input logic           cnt_we,
  input logic [CW-1:0]  cnt_rx,
  input logic [CW-1:0]  cnt_dst_fail,
  input logic [CW-1:0]  cnt_ch_full
);

  p_drop_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> wr_en == '0);

  p_mask_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0 && $past(wr_en) != '0 && !$past(out_last)) |-> wr_en == $past(wr_en));

  p_rx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_rx == $past(cnt_rx) || cnt_rx == $past(cnt_rx) + CW'(1)));

  p_drop_counted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !$past(cnt_we)) |->
      (cnt_dst_fail != $past(cnt_dst_fail) || cnt_ch_full != $past(cnt_ch_full)));

  for (genvar c = 0; c < NCH; c++) begin : g_buf
    p_buf_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[c] && out_last) |=> wr_buf[c] != $past(wr_buf[c]));
    p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en[c] && out_last) |=> $stable(wr_buf[c]));
  end

endmodule

bind rx_mac_steer rx_mac_steer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf), .out_last(out_last),
  .drop(drop), .cnt_we(cnt_we), .cnt_rx(cnt_rx), .cnt_dst_fail(cnt_dst_fail),
  .cnt_ch_full(cnt_ch_full)
);

// File: tb/rx_mac_steer_tb.sv
module rx_mac_steer_tb;
  localparam int NCH   = 8;
  localparam int CW    = 32;
  localparam int T_CLK = 10;
  localparam logic [47:0] MB = 48'h02_11_22_33_40_00;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic [NCH*48-1:0] ch_mac;
  logic [NCH-1:0] ch_vis = '1;
  logic bcast_en = 1'b0;
  logic [2*NCH-1:0] buf_full = '0;
  logic cnt_we = 1'b0;
  logic [1:0] cnt_sel = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [NCH-1:0] wr_en, wr_buf;
  logic [7:0] out_byte;
  logic out_last, drop;
  logic [CW-1:0] cnt_rx, cnt_bc, cnt_dst_fail, cnt_ch_full;

  int n_chk = 0, n_bad = 0;
  int e_rx = 0, e_bc = 0, e_df = 0, e_cf = 0;
  logic [NCH-1:0] e_ptr = '0;
  logic [NCH-1:0] got_mask, got_last, got_buf;
  int got_wr [NCH];
  int got_drop, got_bad;
  bit first_w, done = 1'b0;

  always #(T_CLK/2) clk = ~clk;

  rx_mac_steer #(.NCH(NCH), .CW(CW)) u_dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_cnts(input string req);
    check(cnt_rx == CW'(e_rx), {req, " R10 cnt_rx"}, cnt_rx, e_rx);
    check(cnt_bc == CW'(e_bc), {req, " cnt_bc"}, cnt_bc, e_bc);
    check(cnt_dst_fail == CW'(e_df), {req, " cnt_dst_fail"}, cnt_dst_fail, e_df);
    check(cnt_ch_full == CW'(e_cf), {req, " cnt_ch_full"}, cnt_ch_full, e_cf);
  endtask

  task automatic sample(input logic [7:0] sent, input bit gap);
    if (wr_en != '0) begin
      if (gap || out_byte != sent) got_bad++;
      got_mask |= wr_en;
      for (int c = 0; c < NCH; c++) if (wr_en[c]) got_wr[c]++;
      if (first_w) begin got_buf = wr_buf; first_w = 1'b0; end
      if (out_last) got_last = wr_en;
    end
    if (drop) got_drop++;
  endtask

  task automatic send(input logic [47:0] dst, input int len, input int gap, input int chg_at);
    got_mask = '0; got_last = '0; got_buf = '0; got_drop = 0; got_bad = 0; first_w = 1'b1;
    for (int c = 0; c < NCH; c++) got_wr[c] = 0;
    for (int i = 0; i < len; i++) begin
      for (int g = 0; g < gap && i > 0; g++) begin
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1; sample(8'h00, 1'b1);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = (i < 6) ? dst[47-8*i -: 8] : 8'(i * 7 + 3);
      in_last  = (i == len - 1);
      if (i == chg_at) begin ch_vis = '0; buf_full = '1; bcast_en = 1'b0; end
      @(posedge clk); #1; sample(in_byte, 1'b0);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    @(posedge clk); #1; sample(8'h00, 1'b1);
  endtask

  function automatic logic [47:0] mac(input int c);
    return MB + 48'(c);
  endfunction

  task automatic t_reset();
    check(wr_en == '0 && drop == 1'b0, "R1 outputs", {wr_en, drop}, 0);
    check(wr_buf == '0, "R1 wr_buf", wr_buf, 0);
    check_cnts("R1");
  endtask

  task automatic t_unicast();
    send(mac(3), 20, 0, -1);
    e_rx++; e_ptr[3] = ~e_ptr[3];
    check(got_mask == 8'h08, "R3 unicast mask", got_mask, 8'h08);
    check(got_wr[3] == 15 && got_bad == 0, "R2 write window", got_wr[3], 15);
    check(got_last == 8'h08 && got_drop == 0, "R2 last byte", got_last, 8'h08);
    check(wr_buf == e_ptr, "R7 select flips", wr_buf, e_ptr);
    check_cnts("R3");
  endtask

  task automatic t_gaps();
    send(mac(1), 10, 2, -1);
    e_rx++; e_ptr[1] = ~e_ptr[1];
    check(got_wr[1] == 5 && got_bad == 0, "R2 gapped bytes", got_wr[1], 5);
    check_cnts("R2");
  endtask

  task automatic t_miss();
    send(48'h0A0B_0C0D_0E0F, 12, 0, -1);
    e_rx++; e_df++;
    check(got_mask == '0 && got_drop == 1, "R4 unknown dst", got_drop, 1);
    ch_vis = ~8'h20;
    send(mac(5), 12, 0, -1);
    e_rx++; e_df++;
    check(got_mask == '0 && got_drop == 1, "R4 disabled channel", got_mask, 0);
    ch_vis = '1;
    check_cnts("R4");
  endtask

  task automatic t_priority();
    ch_mac[6*48 +: 48] = mac(4);
    send(mac(4), 9, 0, -1);
    e_rx++; e_ptr[4] = ~e_ptr[4];
    check(got_mask == 8'h10, "R3 lowest index", got_mask, 8'h10);
    ch_mac[6*48 +: 48] = mac(6);
    check_cnts("R3");
  endtask

  task automatic t_bcast();
    send(BC, 10, 0, -1);
    e_rx++; e_bc++; e_df++;
    check(got_mask == '0 && got_drop == 1, "R5 broadcast off", got_drop, 1);
    bcast_en = 1'b1; ch_vis = 8'h7F;
    buf_full[0 + int'(e_ptr[0])] = 1'b1;
    send(BC, 10, 0, -1);
    e_rx++; e_bc++;
    check(got_mask == 8'h7E && got_drop == 0, "R5 broadcast room", got_mask, 8'h7E);
    check(got_wr[2] == 5 && got_wr[7] == 0, "R5 broadcast writes", got_wr[2], 5);
    e_ptr ^= 8'h7E;
    check(wr_buf == e_ptr, "R7 broadcast flips", wr_buf, e_ptr);
    buf_full = '1;
    send(BC, 10, 0, -1);
    e_rx++; e_bc++; e_cf++;
    check(got_mask == '0 && got_drop == 1, "R6 broadcast all full", got_drop, 1);
    buf_full = '0; bcast_en = 1'b0; ch_vis = '1;
    check_cnts("R5");
  endtask

  task automatic t_full();
    buf_full[4 + int'(e_ptr[2])] = 1'b1;
    send(mac(2), 11, 0, -1);
    e_rx++; e_cf++;
    check(got_mask == '0 && got_drop == 1, "R6 unicast full", got_mask, 0);
    check(wr_buf == e_ptr, "R6 select kept", wr_buf, e_ptr);
    buf_full = '0;
    check_cnts("R6");
  endtask

  task automatic t_alternate();
    send(mac(7), 8, 0, -1);
    e_rx++;
    check(got_buf[7] == 1'b0 && got_wr[7] == 3, "R7 first buffer", got_buf[7], 0);
    buf_full[14] = 1'b1;
    send(mac(7), 8, 0, -1);
    e_rx++;
    check(got_buf[7] == 1'b1 && got_wr[7] == 3, "R7 second buffer", got_buf[7], 1);
    buf_full[15] = 1'b1;
    send(mac(7), 8, 0, -1);
    e_rx++; e_cf++;
    check(got_drop == 1 && got_mask == '0, "R7 first buffer still full", got_drop, 1);
    buf_full = '0;
    check_cnts("R7");
  endtask

  task automatic t_hold();
    send(mac(0), 16, 0, 8);
    e_rx++;
    e_ptr[0] = ~e_ptr[0];
    check(got_mask == 8'h01 && got_wr[0] == 11, "R8 decision held", got_wr[0], 11);
    check(wr_buf[0] == e_ptr[0], "R8 select", wr_buf[0], e_ptr[0]);
    ch_vis = '1; buf_full = '0;
    check_cnts("R8");
  endtask

  task automatic t_runt();
    send(mac(1), 4, 0, -1);
    check(got_mask == '0 && got_drop == 0, "R9 four bytes", got_mask, 0);
    send(mac(1), 5, 0, -1);
    check(got_mask == '0 && got_drop == 0, "R9 five bytes", got_mask, 0);
    check_cnts("R9");
    send(mac(1), 6, 0, -1);
    e_rx++;
    check(got_wr[1] == 1 && got_last == 8'h02, "R2 six byte frame", got_wr[1], 1);
  endtask

  task automatic t_load();
    @(negedge clk); cnt_we = 1'b1; cnt_sel = 2'd2; cnt_wdata = 32'd100;
    @(negedge clk); cnt_sel = 2'd0; cnt_wdata = 32'd50;
    @(negedge clk); cnt_we = 1'b0;
    e_df = 100; e_rx = 50;
    check_cnts("R11 load");
    send(48'h0A0B_0C0D_0E0F, 7, 0, -1);
    e_rx++; e_df++;
    check_cnts("R11 after load");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) ch_mac[c*48 +: 48] = mac(c);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_unicast();
    t_gaps();
    t_miss();
    t_priority();
    t_bcast();
    t_full();
    t_alternate();
    t_hold();
    t_runt();
    t_load();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(T_CLK * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule